// File: doc/BRIEF.md
# Line sensor readout sequencer

This block is the digital control core of a 256-pixel linear light sensor. A start pulse, sampled on a rising edge of the readout clock, freezes the integrated pixel voltages into their hold stages. It then steps a pixel-select index through the array, one pixel per clock, towards the output multiplexer. A one-clock discharge pulse, placed on falling edges, clears the integration capacitors early in the run, so the next exposure begins while the current line is still being read out.

The last pixel is held one clock later than the rest and is released one clock later as well. This lets a whole line leave the sensor in exactly 256 clocks. A start that arrives during a readout sends the index back to the first pixel and leaves the held values as they are. When no start comes after the last pixel, the sequencer goes idle. It then shows pixel 1 in sample mode, so the output tracks that pixel's live voltage. A shutter input gates integration at any time.

Top module: `line_readout_seq`

## Requirements
- R1: While `por_n_i` is low, `pix_sel_o` = 1, `run_o` = 0, both hold outputs = 0 (sample mode), `int_clr_n_o` = 0 (discharge commanded) and `int_en_o` = 0.
- R2: A rising edge that samples `start_i` = 1 while `run_o` = 0 is a fresh start. After that edge, `pix_sel_o` = 1, `run_o` = 1 and `hold_main_o` = 1. `hold_last_o` becomes 1 after the following rising edge.
- R3: During a run, each rising edge without a start raises `pix_sel_o` by exactly one. `pix_sel_o` always lies in 1..256. A run with no restart lasts exactly 256 clocks, from the start edge to the edge that ends it.
- R4: The edge that moves the index from 255 to 256 (without a start) clears `hold_main_o`. The next edge, which moves the index from 256 onwards (without a start), clears `hold_last_o`.
- R5: After a fresh start, `int_clr_n_o` is low from the 2nd to the 3rd falling edge after the start edge and is high otherwise once the first falling edge after reset has passed. It changes only on falling edges.
- R6: A start sampled while `run_o` = 1 is a restart. `pix_sel_o` returns to 1 and `run_o` stays 1. Both hold outputs keep their values across that edge. The one exception: a `hold_last_o` entry due from a fresh start on the previous edge still takes place.
- R7: The edge after pixel 256 with no start makes the block idle. It then has `run_o` = 0 and `pix_sel_o` = 1 with both hold outputs 0, and it stays like this until the next start.
- R8: After every rising edge, `int_en_o` equals the inverse of `shutter_i` as sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Readout clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| start_i | input | 1 | Start of readout and integration, sampled on rising edges |
| shutter_i | input | 1 | High stops integration |
| pix_sel_o | output | 9 | Pixel presented to the output multiplexer, 1..256 |
| run_o | output | 1 | A readout is in progress |
| hold_main_o | output | 1 | Hold command for pixels 1..255 (1 = hold) |
| hold_last_o | output | 1 | Hold command for pixel 256 (1 = hold) |
| int_clr_n_o | output | 1 | Integration capacitor discharge, active low |
| int_en_o | output | 1 | Photodiode-to-capacitor connection enable |

## Verification
A wrong index state appears on `pix_sel_o` at the next rising edge. A wrong run flag appears within 256 clocks, as an early or late return to pixel 1. Hold-state errors, such as a restart that re-samples or a missing release, show on the two hold outputs within one clock of the start or the 255/256 boundary. The discharge pulse is checked on both clock phases, so a pulse placed one edge early or late, or one that moves on a rising edge, is caught in the same cycle.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  typedef enum logic [1:0] {
    CLR_QUIET = 2'd0,
    CLR_ARMED = 2'd1,
    CLR_FIRE  = 2'd2
  } clr_phase_e;

  // index 0 is idle; 1..npix are the pixels shown during a run
  function automatic int lsq_next_idx(int cur, int npix, logic start);
    if (start)        return 1;
    if (cur == 0)     return 0;
    if (cur >= npix)  return 0;
    return cur + 1;
  endfunction

  function automatic int lsq_shown_idx(int cur);
    return (cur == 0) ? 1 : cur;
  endfunction

  function automatic clr_phase_e lsq_next_phase(clr_phase_e cur, logic fresh);
    if (fresh) return CLR_ARMED;
    if (cur == CLR_ARMED) return CLR_FIRE;
    return CLR_QUIET;
  endfunction

endpackage

// File: rtl/lsq_index_ctr.sv
module lsq_index_ctr
  import lsq_pkg::*;
#(
  parameter int NPIX = 256,
  parameter int IDXW = $clog2(NPIX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_n,
  input  logic            start_i,
  output logic [IDXW-1:0] idx_o,
  output logic            run_o,
  output logic            fresh_o,
  output logic            restart_o,
  output logic            at_prelast_o,
  output logic            at_last_o
);

  localparam logic [IDXW-1:0] LAST    = IDXW'(NPIX);
  localparam logic [IDXW-1:0] PRELAST = IDXW'(NPIX - 1);

  logic [IDXW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= IDXW'(lsq_next_idx(int'(32'(idx_q)), NPIX, start_i));
  end

  assign idx_o        = idx_q;
  assign run_o        = (idx_q != '0);
  assign fresh_o      = start_i && !run_o;
  assign restart_o    = start_i && run_o;
  assign at_prelast_o = (idx_q == PRELAST);
  assign at_last_o    = (idx_q == LAST);

  p_start_first_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i |=> (idx_q == IDXW'(1))) else $error("start did not load pixel 1");

  p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_o && !start_i && !at_last_o) |=> (idx_q == $past(idx_q) + IDXW'(1)))
    else $error("index did not advance by one");

  p_end_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (at_last_o && !start_i) |=> !run_o) else $error("run did not end after last pixel");

  p_idle_stays_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run_o && !start_i) |=> !run_o) else $error("idle left without start");

endmodule

// File: rtl/lsq_hold_ctl.sv
module lsq_hold_ctl (
  input  logic clk_i,
  input  logic rst_n,
  input  logic start_i,
  input  logic fresh_i,
  input  logic at_prelast_i,
  input  logic at_last_i,
  output logic hold_main_o,
  output logic hold_last_o
);

  logic hold_main_q;
  logic hold_last_q;
  logic last_arm_q;
  logic rel_main;
  logic rel_last;

  assign rel_main = at_prelast_i && !start_i;
  assign rel_last = at_last_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      hold_main_q <= 1'b0;
      hold_last_q <= 1'b0;
      last_arm_q  <= 1'b0;
    end else begin
      last_arm_q <= fresh_i;
      if (fresh_i)       hold_main_q <= 1'b1;
      else if (rel_main) hold_main_q <= 1'b0;
      if (last_arm_q)    hold_last_q <= 1'b1;
      else if (rel_last) hold_last_q <= 1'b0;
    end
  end

  assign hold_main_o = hold_main_q;
  assign hold_last_o = hold_last_q;

  p_last_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    fresh_i |=> (hold_main_q && !$past(hold_last_q) ##1 hold_last_q))
    else $error("pixel 256 hold did not follow one clock later");

  p_restart_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && !fresh_i && !last_arm_q) |=>
      (hold_main_q == $past(hold_main_q) && hold_last_q == $past(hold_last_q)))
    else $error("restart changed a hold state");

  p_main_release_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    rel_main |=> !hold_main_q) else $error("main hold not released");

  p_last_release_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    rel_last |=> !hold_last_q) else $error("last hold not released");

endmodule

// File: rtl/lsq_integ_ctl.sv
module lsq_integ_ctl
  import lsq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n,
  input  logic fresh_i,
  input  logic shutter_i,
  output logic int_clr_n_o,
  output logic int_en_o
);

  clr_phase_e phase_q;
  logic       clr_n_q;
  logic       en_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= CLR_QUIET;
      en_q    <= 1'b0;
    end else begin
      phase_q <= lsq_next_phase(phase_q, fresh_i);
      en_q    <= !shutter_i;
    end
  end

  // discharge pulse lives on falling edges only
  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) clr_n_q <= 1'b0;
    else        clr_n_q <= (phase_q != CLR_FIRE);
  end

  assign int_clr_n_o = clr_n_q;
  assign int_en_o    = en_q;

  p_clr_window_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    fresh_i |=> (clr_n_q ##1 !clr_n_q ##1 clr_n_q))
    else $error("discharge pulse misplaced");

  p_shutter_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> (en_q == !$past(shutter_i))) else $error("integration enable wrong");

endmodule

// File: rtl/line_readout_seq.sv
module line_readout_seq
  import lsq_pkg::*;
#(
  parameter int NPIX = 256,
  parameter int IDXW = $clog2(NPIX + 1)
) (
  input  logic            clk_i,
  input  logic            por_n_i,
  input  logic            start_i,
  input  logic            shutter_i,
  output logic [IDXW-1:0] pix_sel_o,
  output logic            run_o,
  output logic            hold_main_o,
  output logic            hold_last_o,
  output logic            int_clr_n_o,
  output logic            int_en_o
);

  logic [IDXW-1:0] idx;
  logic            run;
  logic            fresh;
  logic            restart;
  logic            at_prelast;
  logic            at_last;

  lsq_index_ctr #(.NPIX(NPIX), .IDXW(IDXW)) u_idx (
    .clk_i        (clk_i),
    .rst_n        (por_n_i),
    .start_i      (start_i),
    .idx_o        (idx),
    .run_o        (run),
    .fresh_o      (fresh),
    .restart_o    (restart),
    .at_prelast_o (at_prelast),
    .at_last_o    (at_last)
  );

  lsq_hold_ctl u_hold (
    .clk_i        (clk_i),
    .rst_n        (por_n_i),
    .start_i      (start_i),
    .fresh_i      (fresh),
    .at_prelast_i (at_prelast),
    .at_last_i    (at_last),
    .hold_main_o  (hold_main_o),
    .hold_last_o  (hold_last_o)
  );

  lsq_integ_ctl u_integ (
    .clk_i       (clk_i),
    .rst_n       (por_n_i),
    .fresh_i     (fresh),
    .shutter_i   (shutter_i),
    .int_clr_n_o (int_clr_n_o),
    .int_en_o    (int_en_o)
  );

  assign pix_sel_o = IDXW'(lsq_shown_idx(int'(32'(idx))));
  assign run_o     = run;

  p_idle_sample_r7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !run |-> (!hold_main_o && !hold_last_o)) else $error("hold active while idle");

  p_sel_range_r3: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (pix_sel_o >= IDXW'(1)) && (pix_sel_o <= IDXW'(NPIX))) else $error("index out of range");

  p_restart_run_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    restart |=> (run && pix_sel_o == IDXW'(1))) else $error("restart failed");

  always_comb begin
    if (!por_n_i) begin
      p_reset_state_r1: assert (!hold_main_o && !hold_last_o && !int_clr_n_o && !int_en_o)
        else $error("reset state wrong");
    end
  end

endmodule

// File: tb/line_readout_seq_bench.sv
module line_readout_seq_bench;

  localparam int NPIX = 256;
  localparam int IDXW = $clog2(NPIX + 1);

  logic            clk = 1'b0;
  logic            por_n = 1'b0;
  logic            start = 1'b0;
  logic            shutter = 1'b0;
  logic [IDXW-1:0] pix_sel;
  logic            run, hold_main, hold_last, int_clr_n, int_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side expectation
  int b_pos   = 0;   // 0 = idle, else pixel being shown
  int b_since = 99;  // rising edges since last fresh start
  bit b_hm = 0, b_hl = 0, b_en = 0;

  always #5 clk = ~clk;

  line_readout_seq #(.NPIX(NPIX), .IDXW(IDXW)) u_line_readout_seq (
    .clk_i(clk), .por_n_i(por_n), .start_i(start), .shutter_i(shutter),
    .pix_sel_o(pix_sel), .run_o(run), .hold_main_o(hold_main), .hold_last_o(hold_last),
    .int_clr_n_o(int_clr_n), .int_en_o(int_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int shown(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic model_edge(input bit s, input bit d);
    bit was_run = (b_pos != 0);
    int old_pos = b_pos;
    bit fresh_now = s && !was_run;
    if (fresh_now) b_since = 0;
    else if (b_since < 99) b_since++;
    if (s) b_pos = 1;
    else if (was_run) b_pos = (old_pos == NPIX) ? 0 : old_pos + 1;
    if (fresh_now) b_hm = 1;
    else if (!s && old_pos == NPIX - 1) b_hm = 0;
    if (b_since == 1) b_hl = 1;
    else if (!s && old_pos == NPIX) b_hl = 0;
    b_en = !d;
  endtask

  task automatic step(input bit s, input bit d);
    start = s;
    shutter = d;
    @(posedge clk);
    model_edge(s, d);
    #2;
    chk("R3 pix_sel", int'(pix_sel), shown(b_pos));
    chk("R7 run", int'(run), int'(b_pos != 0));
    chk("R2/R4/R6 hold_main", int'(hold_main), int'(b_hm));
    chk("R2/R4/R6 hold_last", int'(hold_last), int'(b_hl));
    chk("R8 int_en", int'(int_en), int'(b_en));
    chk("R5 clr stable at rise", int'(int_clr_n), int'(b_since != 2));
    @(negedge clk);
    #2;
    chk("R5 int_clr_n", int'(int_clr_n), int'(b_since != 1));
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd20240611);
    #12;
    // R1: reset state
    chk("R1 pix_sel", int'(pix_sel), 1);
    chk("R1 run", int'(run), 0);
    chk("R1 hold_main", int'(hold_main), 0);
    chk("R1 hold_last", int'(hold_last), 0);
    chk("R1 int_clr_n", int'(int_clr_n), 0);
    chk("R1 int_en", int'(int_en), 0);
    @(posedge clk); #2;
    por_n = 1'b1;
    @(negedge clk); #2;
    chk("R5 clr released", int'(int_clr_n), 1);

    // full run then free-running idle (R2, R3, R4, R7)
    step(1, 0);
    chk("R2 fresh start pix 1", int'(pix_sel), 1);
    repeat (NPIX + 20) step(0, 0);
    chk("R7 idle after run", int'(run), 0);

    // restart mid-run (R6)
    step(1, 1);
    repeat (100) step(0, 1);
    step(1, 0);
    chk("R6 restart pix 1", int'(pix_sel), 1);
    while (b_pos != 255) step(0, 0);
    step(1, 0);               // restart on pixel 255 keeps main hold
    chk("R6 restart at 255 keeps hold", int'(hold_main), 1);
    while (b_pos != NPIX) step(0, 0);
    step(1, 0);               // restart on pixel 256
    while (b_pos != 0) step(0, 0);

    // restart one clock after a fresh start
    step(1, 0);
    step(1, 0);
    chk("R6 pending last hold completes", int'(hold_last), 1);
    while (b_pos != 0) step(0, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit s = (($urandom % 200) == 0);
      bit d = (($urandom % 4) == 0);
      step(s, d);
    end
    while (b_pos != 0) step(0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule